// File: doc/BRIEF.md
# DMA Command Queue with Tag-Group Ordering

This block sits between the command sources of a DMA engine and the engine itself. A local processor port and a proxy port each push DMA commands into a queue of their own. Every command carries a local address, an external address, a byte count, a 5-bit tag group and three modifier flags. Commands that fail the size or alignment rules are dropped at entry and raise an error pulse. Commands that are accepted wait until the ordering rules of their tag group allow them to start. They are then handed to the transfer engine under an in-flight identifier, and they stay outstanding until the engine returns a completion pulse carrying that identifier.

A fenced command waits for its group to drain. A barriered command also holds back the later commands of its group. A sync command holds back everything queued behind it on its port. Software can ask which tag groups are idle. It can get the answer at once, or have the block wait until any one of the masked groups is idle, or until all of them are.

Top module: `dma_tag_queue`

## Requirements
- R1: The processor queue holds 16 commands and the proxy queue 8. `pu_vacancy` (and `px_ready` for the proxy) is 1 whenever its queue has a free entry. A command presented while the flag is 0 is ignored: it is never issued and raises no error.
- R2: A command is legal when its size is 1, 2, 4 or 8, or a nonzero multiple of 16 no larger than 16384. For sizes below 16 both addresses must be multiples of the size, and for larger sizes both addresses must be multiples of 16. An illegal command is dropped and `cmd_err` is 1 for exactly the cycle after it was presented. The size and alignment rules do not apply to a sync command.
- R3: Commands without modifiers issue at most one per cycle on `iss_*`. Within one port, the oldest eligible command goes first. When both ports have a candidate, the grant alternates between them.
- R4: A command with `fence`=1 starts only when no older command of its tag group is waiting on its port and no command of that group is in flight.
- R5: A command with `barrier`=1 obeys R4. While it is still queued, no younger command of its tag group on that port may start. Commands of other groups are not held back.
- R6: A command with `sync`=1 is never issued. While it is queued, no younger command on its port starts. It leaves the queue once it is the oldest entry and no command is in flight.
- R7: At most 16 commands are in flight at once. `iss_id` is an identifier that is not in use. A `done_valid` pulse with that identifier frees it, and a held-back command can then start.
- R8: `qry_mode`=0 (and 3) is an immediate query. `stat_valid` pulses for one cycle, with `stat_tags` = `qry_mask` AND idle. A group is idle when none of its commands is queued or in flight.
- R9: `qry_mode`=1 answers only once at least one masked group is idle.
- R10: `qry_mode`=2 answers only once every masked group is idle.
- R11: The proxy port applies the same legality and ordering rules as the processor port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| pu_valid | input | 1 | processor command present |
| pu_laddr | input | 32 | processor command local address |
| pu_eaddr | input | 64 | processor command external address |
| pu_size | input | 15 | processor command byte count |
| pu_tag | input | 5 | processor command tag group |
| pu_fence | input | 1 | processor command fence flag |
| pu_barrier | input | 1 | processor command barrier flag |
| pu_sync | input | 1 | processor sync command |
| pu_vacancy | output | 1 | processor queue has a free entry |
| px_valid | input | 1 | proxy command present |
| px_laddr | input | 32 | proxy command local address |
| px_eaddr | input | 64 | proxy command external address |
| px_size | input | 15 | proxy command byte count |
| px_tag | input | 5 | proxy command tag group |
| px_fence | input | 1 | proxy command fence flag |
| px_barrier | input | 1 | proxy command barrier flag |
| px_sync | input | 1 | proxy sync command |
| px_ready | output | 1 | proxy queue has a free entry |
| cmd_err | output | 1 | a command was dropped in the previous cycle |
| iss_valid | output | 1 | a command starts this cycle |
| iss_id | output | 4 | in-flight identifier of the started command |
| iss_laddr | output | 32 | local address of the started command |
| iss_eaddr | output | 64 | external address of the started command |
| iss_size | output | 15 | byte count of the started command |
| iss_tag | output | 5 | tag group of the started command |
| done_valid | input | 1 | completion pulse from the transfer engine |
| done_id | input | 4 | identifier of the completed command |
| qry_valid | input | 1 | tag status request |
| qry_mode | input | 2 | 0 immediate, 1 any, 2 all |
| qry_mask | input | 32 | tag groups of interest |
| stat_valid | output | 1 | tag status answer pulse |
| stat_tags | output | 32 | masked idle groups |

## Verification
The bench drives plain commands on unrelated groups to expose the age order. It then holds a completion back under each modifier in turn, which separates a fence (only its own group stalls), a barrier (later commands of the group stall while a different group overtakes) and a sync (every later command stalls, whatever its group). A burst of 32 back-to-back commands without completions shows the cap on outstanding work and the full-queue drop. Sizes and addresses just inside and just outside each legality rule show which commands are dropped. Queries are issued over groups that are partly busy, so immediate, any and all answers each differ in when they arrive and which bits they carry.

// File: rtl/dcq_pkg.sv
`timescale 1ns/1ps
package dcq_pkg;
    localparam int LA_W     = 32;
    localparam int EA_W     = 64;
    localparam int SIZE_W   = 15;
    localparam int TAG_W    = 5;
    localparam int NTAG     = 1 << TAG_W;
    localparam int MAX_XFER = 16384;
    localparam int LINE_B   = 16;

    typedef struct packed {
        logic [LA_W-1:0]   laddr;
        logic [EA_W-1:0]   eaddr;
        logic [SIZE_W-1:0] size;
        logic [TAG_W-1:0]  tag;
        logic              fence;
        logic              barrier;
        logic              sync;
    } dcq_cmd_t;

    typedef enum logic [1:0] {
        QRY_NOW = 2'd0,
        QRY_ANY = 2'd1,
        QRY_ALL = 2'd2,
        QRY_RSV = 2'd3
    } qry_mode_e;
endpackage

// File: rtl/dcq_check.sv
`timescale 1ns/1ps
module dcq_check
    import dcq_pkg::*;
(
    input  dcq_cmd_t cmd,
    output logic     ok
);
    logic              small_sz;
    logic              line_sz;
    logic [SIZE_W-1:0] amask;
    logic              aligned;

    always_comb begin
        small_sz = (cmd.size == SIZE_W'(1)) || (cmd.size == SIZE_W'(2)) ||
                   (cmd.size == SIZE_W'(4)) || (cmd.size == SIZE_W'(8));
        line_sz  = (cmd.size[3:0] == 4'd0) && (cmd.size != '0) &&
                   (cmd.size <= SIZE_W'(MAX_XFER));
        amask    = small_sz ? (cmd.size - SIZE_W'(1)) : SIZE_W'(LINE_B - 1);
        aligned  = ((cmd.laddr[SIZE_W-1:0] & amask) == '0) &&
                   ((cmd.eaddr[SIZE_W-1:0] & amask) == '0);
        ok       = cmd.sync || ((small_sz || line_sz) && aligned);
    end
endmodule

// File: rtl/dcq_queue.sv
`timescale 1ns/1ps
module dcq_queue
    import dcq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  dcq_cmd_t               wr_cmd,
    input  logic [NTAG-1:0]        infl_busy,
    input  logic                   infl_empty,
    input  logic                   take,
    output logic                   full,
    output logic                   cand_valid,
    output dcq_cmd_t               cand_cmd,
    output logic [NTAG-1:0]        tag_wait,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        dcq_cmd_t [DEPTH-1:0] ent;
        logic [CW-1:0]        cnt;
    } qstate_t;

    qstate_t         q, d;
    logic [IW-1:0]   cand_idx;
    logic            sync_ret;

    always_comb begin
        logic          seen_sync;
        logic          older_same;
        logic          older_bar;
        logic          elig;
        logic          rm;
        logic [IW-1:0] rm_idx;
        logic [CW-1:0] cnt_after;

        d          = q;
        cand_valid = 1'b0;
        cand_idx   = '0;
        sync_ret   = 1'b0;
        tag_wait   = '0;
        seen_sync  = 1'b0;

        // age order: index 0 is the oldest live entry
        for (int i = 0; i < DEPTH; i++) begin
            older_same = 1'b0;
            older_bar  = 1'b0;
            elig       = 1'b0;
            if (CW'(i) < q.cnt) begin
                if (q.ent[i].sync) begin
                    if (i == 0 && infl_empty) sync_ret = 1'b1;
                    seen_sync = 1'b1;
                end else begin
                    tag_wait[q.ent[i].tag] = 1'b1;
                    for (int j = 0; j < DEPTH; j++) begin
                        if (j < i && !q.ent[j].sync && q.ent[j].tag == q.ent[i].tag) begin
                            older_same = 1'b1;
                            if (q.ent[j].barrier) older_bar = 1'b1;
                        end
                    end
                    elig = !seen_sync && !older_bar &&
                           (!(q.ent[i].fence || q.ent[i].barrier) ||
                            (!older_same && !infl_busy[q.ent[i].tag]));
                    if (elig && !cand_valid) begin
                        cand_valid = 1'b1;
                        cand_idx   = IW'(i);
                    end
                end
            end
        end
        if (sync_ret) cand_valid = 1'b0;

        // remove one entry (issued command or retired sync), compact, append
        rm        = sync_ret || take;
        rm_idx    = sync_ret ? '0 : cand_idx;
        cnt_after = q.cnt - CW'(rm);
        for (int k = 0; k < DEPTH - 1; k++) begin
            if (rm && IW'(k) >= rm_idx) d.ent[k] = q.ent[k+1];
        end
        if (rm) d.ent[DEPTH-1] = '0;
        if (wr_en) d.ent[cnt_after[IW-1:0]] = wr_cmd;
        d.cnt = cnt_after + CW'(wr_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full     = (q.cnt == CW'(DEPTH));
    assign cand_cmd = q.ent[cand_idx];
    assign count    = q.cnt;
endmodule

// File: rtl/dcq_inflight.sv
`timescale 1ns/1ps
module dcq_inflight
    import dcq_pkg::*;
#(
    parameter int SLOTS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_en,
    input  logic [TAG_W-1:0]         alloc_tag,
    input  logic                     free_en,
    input  logic [$clog2(SLOTS)-1:0] free_id,
    output logic [$clog2(SLOTS)-1:0] alloc_id,
    output logic                     full,
    output logic                     empty,
    output logic [NTAG-1:0]          busy
);
    localparam int IDW = $clog2(SLOTS);

    typedef struct packed {
        logic [SLOTS-1:0]                vld;
        logic [SLOTS-1:0][TAG_W-1:0]     tag;
    } istate_t;

    istate_t q, d;

    always_comb begin
        logic found;
        d        = q;
        alloc_id = '0;
        found    = 1'b0;
        busy     = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!q.vld[s] && !found) begin
                alloc_id = IDW'(s);
                found    = 1'b1;
            end
            if (q.vld[s]) busy[q.tag[s]] = 1'b1;
        end
        if (free_en) d.vld[free_id] = 1'b0;
        if (alloc_en) begin
            d.vld[alloc_id] = 1'b1;
            d.tag[alloc_id] = alloc_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full  = &q.vld;
    assign empty = ~|q.vld;
endmodule

// File: rtl/dcq_tagstat.sv
`timescale 1ns/1ps
module dcq_tagstat
    import dcq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            qry_valid,
    input  logic [1:0]      qry_mode,
    input  logic [NTAG-1:0] qry_mask,
    input  logic [NTAG-1:0] idle,
    output logic            stat_valid,
    output logic [NTAG-1:0] stat_tags
);
    typedef struct packed {
        logic            pend;
        qry_mode_e       mode;
        logic [NTAG-1:0] mask;
        logic            sv;
        logic [NTAG-1:0] st;
    } sstate_t;

    sstate_t q, d;

    always_comb begin
        logic            hit;
        logic [NTAG-1:0] sel;
        d    = q;
        d.sv = 1'b0;
        sel  = q.mask & idle;
        unique case (q.mode)
            QRY_ANY: hit = |sel;
            QRY_ALL: hit = (sel == q.mask);
            default: hit = 1'b1;
        endcase
        if (q.pend && hit) begin
            d.sv   = 1'b1;
            d.st   = sel;
            d.pend = 1'b0;
        end
        if (qry_valid) begin
            d.pend = 1'b1;
            d.mode = qry_mode_e'(qry_mode);
            d.mask = qry_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stat_valid = q.sv;
    assign stat_tags  = q.st;
endmodule

// File: rtl/dma_tag_queue.sv
`timescale 1ns/1ps
module dma_tag_queue
    import dcq_pkg::*;
#(
    parameter int PU_DEPTH = 16,
    parameter int PX_DEPTH = 8,
    parameter int MAX_OUT  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pu_valid,
    input  logic [LA_W-1:0]            pu_laddr,
    input  logic [EA_W-1:0]            pu_eaddr,
    input  logic [SIZE_W-1:0]          pu_size,
    input  logic [TAG_W-1:0]           pu_tag,
    input  logic                       pu_fence,
    input  logic                       pu_barrier,
    input  logic                       pu_sync,
    output logic                       pu_vacancy,
    input  logic                       px_valid,
    input  logic [LA_W-1:0]            px_laddr,
    input  logic [EA_W-1:0]            px_eaddr,
    input  logic [SIZE_W-1:0]          px_size,
    input  logic [TAG_W-1:0]           px_tag,
    input  logic                       px_fence,
    input  logic                       px_barrier,
    input  logic                       px_sync,
    output logic                       px_ready,
    output logic                       cmd_err,
    output logic                       iss_valid,
    output logic [$clog2(MAX_OUT)-1:0] iss_id,
    output logic [LA_W-1:0]            iss_laddr,
    output logic [EA_W-1:0]            iss_eaddr,
    output logic [SIZE_W-1:0]          iss_size,
    output logic [TAG_W-1:0]           iss_tag,
    input  logic                       done_valid,
    input  logic [$clog2(MAX_OUT)-1:0] done_id,
    input  logic                       qry_valid,
    input  logic [1:0]                 qry_mode,
    input  logic [NTAG-1:0]            qry_mask,
    output logic                       stat_valid,
    output logic [NTAG-1:0]            stat_tags
);
    localparam int IDW  = $clog2(MAX_OUT);
    localparam int PUCW = $clog2(PU_DEPTH + 1);
    localparam int PXCW = $clog2(PX_DEPTH + 1);

    typedef struct packed {
        logic rr;
        logic err;
    } tstate_t;

    tstate_t q, d;

    dcq_cmd_t        pu_cmd, px_cmd, pu_cand, px_cand, iss_cmd;
    logic            pu_ok, px_ok, pu_full, px_full, pu_wr, px_wr;
    logic            pu_cv, px_cv, pu_take, px_take;
    logic [NTAG-1:0] pu_wait, px_wait, infl_busy, tag_idle;
    logic            infl_full, infl_empty;
    logic [PUCW-1:0] pu_cnt;
    logic [PXCW-1:0] px_cnt;

    assign pu_cmd = '{laddr: pu_laddr, eaddr: pu_eaddr, size: pu_size, tag: pu_tag,
                      fence: pu_fence, barrier: pu_barrier, sync: pu_sync};
    assign px_cmd = '{laddr: px_laddr, eaddr: px_eaddr, size: px_size, tag: px_tag,
                      fence: px_fence, barrier: px_barrier, sync: px_sync};

    dcq_check u_pu_check (.cmd(pu_cmd), .ok(pu_ok));
    dcq_check u_px_check (.cmd(px_cmd), .ok(px_ok));

    assign pu_wr = pu_valid && pu_ok && !pu_full;
    assign px_wr = px_valid && px_ok && !px_full;

    dcq_queue #(.DEPTH(PU_DEPTH)) u_pu_queue (
        .clk(clk), .rst_n(rst_n), .wr_en(pu_wr), .wr_cmd(pu_cmd),
        .infl_busy(infl_busy), .infl_empty(infl_empty), .take(pu_take),
        .full(pu_full), .cand_valid(pu_cv), .cand_cmd(pu_cand),
        .tag_wait(pu_wait), .count(pu_cnt)
    );

    dcq_queue #(.DEPTH(PX_DEPTH)) u_px_queue (
        .clk(clk), .rst_n(rst_n), .wr_en(px_wr), .wr_cmd(px_cmd),
        .infl_busy(infl_busy), .infl_empty(infl_empty), .take(px_take),
        .full(px_full), .cand_valid(px_cv), .cand_cmd(px_cand),
        .tag_wait(px_wait), .count(px_cnt)
    );

    dcq_inflight #(.SLOTS(MAX_OUT)) u_inflight (
        .clk(clk), .rst_n(rst_n), .alloc_en(iss_valid), .alloc_tag(iss_cmd.tag),
        .free_en(done_valid), .free_id(done_id), .alloc_id(iss_id),
        .full(infl_full), .empty(infl_empty), .busy(infl_busy)
    );

    assign tag_idle = ~(infl_busy | pu_wait | px_wait);

    dcq_tagstat u_tagstat (
        .clk(clk), .rst_n(rst_n), .qry_valid(qry_valid), .qry_mode(qry_mode),
        .qry_mask(qry_mask), .idle(tag_idle), .stat_valid(stat_valid),
        .stat_tags(stat_tags)
    );

    always_comb begin
        logic pick_px;
        d       = q;
        pick_px = px_cv && (!pu_cv || q.rr);
        pu_take = !infl_full && pu_cv && !pick_px;
        px_take = !infl_full && pick_px;
        iss_cmd = px_take ? px_cand : pu_cand;
        if (pu_take && px_cv) d.rr = 1'b1;
        if (px_take && pu_cv) d.rr = 1'b0;
        d.err = (pu_valid && !pu_full && !pu_ok) || (px_valid && !px_full && !px_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign iss_valid  = pu_take || px_take;
    assign iss_laddr  = iss_cmd.laddr;
    assign iss_eaddr  = iss_cmd.eaddr;
    assign iss_size   = iss_cmd.size;
    assign iss_tag    = iss_cmd.tag;
    assign cmd_err    = q.err;
    assign pu_vacancy = !pu_full;
    assign px_ready   = !px_full;
endmodule

// File: rtl/dcq_checker.sv
`timescale 1ns/1ps
module dcq_checker
    import dcq_pkg::*;
#(
    parameter int PU_DEPTH = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          pu_valid,
    input logic                          pu_vacancy,
    input logic                          px_valid,
    input logic                          cmd_err,
    input logic                          iss_valid,
    input dcq_cmd_t                      iss_cmd,
    input logic                          infl_full,
    input logic [NTAG-1:0]               infl_busy,
    input logic                          pu_take,
    input logic                          px_take,
    input logic [$clog2(PU_DEPTH+1)-1:0] pu_cnt
);
    // R1: a write offered to a full processor queue never grows it
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_valid && !pu_vacancy) |=> (pu_cnt <= $past(pu_cnt)));

    // R2: the error pulse always follows an offered command
    p_err_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(pu_valid || px_valid));

    // R3: at most one port is granted per cycle
    p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pu_take, px_take}));

    // R4 and R5: an ordered command never starts while its group is in flight
    p_fence_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_cmd.fence || iss_cmd.barrier)) |-> !infl_busy[iss_cmd.tag]);

    // R6: a sync command is never handed to the engine
    p_sync_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !iss_cmd.sync);

    // R7: nothing starts while every identifier is taken
    p_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !infl_full);
endmodule

bind dma_tag_queue dcq_checker #(.PU_DEPTH(PU_DEPTH)) i_dcq_checker (
    .clk(clk), .rst_n(rst_n), .pu_valid(pu_valid), .pu_vacancy(pu_vacancy),
    .px_valid(px_valid), .cmd_err(cmd_err), .iss_valid(iss_valid),
    .iss_cmd(iss_cmd), .infl_full(infl_full), .infl_busy(infl_busy),
    .pu_take(pu_take), .px_take(px_take), .pu_cnt(pu_cnt)
);

// File: tb/test_dma_tag_queue.sv
`timescale 1ns/1ps
module test_dma_tag_queue;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pu_valid, pu_fence, pu_barrier, pu_sync, pu_vacancy;
    logic [31:0] pu_laddr;
    logic [63:0] pu_eaddr;
    logic [14:0] pu_size;
    logic [4:0]  pu_tag;
    logic        px_valid, px_fence, px_barrier, px_sync, px_ready;
    logic [31:0] px_laddr;
    logic [63:0] px_eaddr;
    logic [14:0] px_size;
    logic [4:0]  px_tag;
    logic        cmd_err, iss_valid;
    logic [3:0]  iss_id;
    logic [31:0] iss_laddr;
    logic [63:0] iss_eaddr;
    logic [14:0] iss_size;
    logic [4:0]  iss_tag;
    logic        done_valid;
    logic [3:0]  done_id;
    logic        qry_valid;
    logic [1:0]  qry_mode;
    logic [31:0] qry_mask;
    logic        stat_valid;
    logic [31:0] stat_tags;

    always #2.5 clk = ~clk;

    dma_tag_queue i_dma_tag_queue (
        .clk(clk), .rst_n(rst_n),
        .pu_valid(pu_valid), .pu_laddr(pu_laddr), .pu_eaddr(pu_eaddr), .pu_size(pu_size),
        .pu_tag(pu_tag), .pu_fence(pu_fence), .pu_barrier(pu_barrier), .pu_sync(pu_sync),
        .pu_vacancy(pu_vacancy),
        .px_valid(px_valid), .px_laddr(px_laddr), .px_eaddr(px_eaddr), .px_size(px_size),
        .px_tag(px_tag), .px_fence(px_fence), .px_barrier(px_barrier), .px_sync(px_sync),
        .px_ready(px_ready), .cmd_err(cmd_err),
        .iss_valid(iss_valid), .iss_id(iss_id), .iss_laddr(iss_laddr), .iss_eaddr(iss_eaddr),
        .iss_size(iss_size), .iss_tag(iss_tag), .done_valid(done_valid), .done_id(done_id),
        .qry_valid(qry_valid), .qry_mode(qry_mode), .qry_mask(qry_mask),
        .stat_valid(stat_valid), .stat_tags(stat_tags)
    );

    int          vectors = 0;
    int          miscompares = 0;
    int          iss_total = 0;
    bit          finished = 1'b0;
    bit          stat_seen = 1'b0;
    logic [31:0] stat_last;
    logic [31:0] exp_q[$];
    logic [3:0]  id_of[logic [31:0]];

    task automatic chk(string req, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard of issue order, and status capture
    always @(negedge clk) begin
        if (rst_n && iss_valid) begin
            logic [31:0] e;
            iss_total++;
            id_of[iss_laddr] = iss_id;
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R3 unexpected issue actual=%0h expected=none", iss_laddr);
            end else begin
                e = exp_q.pop_front();
                if (e != iss_laddr) begin
                    miscompares++;
                    $display("FAIL R3 issue order actual=%0h expected=%0h", iss_laddr, e);
                end
            end
        end
        if (rst_n && stat_valid) begin
            stat_seen = 1'b1;
            stat_last = stat_tags;
        end
    end

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(bit on_px, logic [31:0] la, logic [63:0] ea, int sz, int tg,
                        bit f, bit b, bit s);
        if (!on_px) begin
            pu_valid = 1; pu_laddr = la; pu_eaddr = ea; pu_size = 15'(sz);
            pu_tag = 5'(tg); pu_fence = f; pu_barrier = b; pu_sync = s;
        end else begin
            px_valid = 1; px_laddr = la; px_eaddr = ea; px_size = 15'(sz);
            px_tag = 5'(tg); px_fence = f; px_barrier = b; px_sync = s;
        end
        @(posedge clk); #1;
        pu_valid = 0; px_valid = 0;
    endtask

    task automatic expect_iss(logic [31:0] la);
        exp_q.push_back(la);
    endtask

    task automatic finish_cmd(logic [31:0] la);
        done_valid = 1; done_id = id_of[la];
        @(posedge clk); #1;
        done_valid = 0;
    endtask

    task automatic query(int mode, logic [31:0] mask);
        stat_seen = 1'b0;
        qry_valid = 1; qry_mode = 2'(mode); qry_mask = mask;
        @(posedge clk); #1;
        qry_valid = 0;
    endtask

    task automatic wait_stat(int n);
        for (int i = 0; i < n && !stat_seen; i++) cycles(1);
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=done");
            report();
        end
    end

    initial begin
        int base;
        rst_n = 0;
        pu_valid = 0; pu_laddr = 0; pu_eaddr = 0; pu_size = 0; pu_tag = 0;
        pu_fence = 0; pu_barrier = 0; pu_sync = 0;
        px_valid = 0; px_laddr = 0; px_eaddr = 0; px_size = 0; px_tag = 0;
        px_fence = 0; px_barrier = 0; px_sync = 0;
        done_valid = 0; done_id = 0; qry_valid = 0; qry_mode = 0; qry_mask = 0;
        cycles(3);
        rst_n = 1;
        cycles(1);

        // reset state
        chk("R1 reset vacancy", pu_vacancy, 1);
        chk("R1 reset proxy ready", px_ready, 1);
        chk("R3 reset issue", iss_valid, 0);
        chk("R2 reset error", cmd_err, 0);
        chk("R8 reset status", stat_valid, 0);

        // R3: plain commands go in age order
        base = iss_total;
        expect_iss(32'h100); expect_iss(32'h200); expect_iss(32'h300);
        push(0, 32'h100, 64'h1000, 16, 1, 0, 0, 0);
        push(0, 32'h200, 64'h2000, 16, 2, 0, 0, 0);
        push(0, 32'h300, 64'h3000, 16, 3, 0, 0, 0);
        cycles(3);
        chk("R3 plain issue count", iss_total, base + 3);
        finish_cmd(32'h100); finish_cmd(32'h200); finish_cmd(32'h300);

        // R4: fence waits for its group
        base = iss_total;
        expect_iss(32'h400);
        push(0, 32'h400, 64'h4000, 32, 4, 0, 0, 0);
        push(0, 32'h410, 64'h4100, 32, 4, 1, 0, 0);
        cycles(5);
        chk("R4 fenced command held", iss_total, base + 1);
        expect_iss(32'h410);
        finish_cmd(32'h400);
        cycles(3);
        chk("R4 fenced command released", iss_total, base + 2);
        finish_cmd(32'h410);

        // R5: barrier holds later commands of its group, other groups pass
        base = iss_total;
        expect_iss(32'h500);
        push(0, 32'h500, 64'h5000, 16, 6, 0, 0, 0);
        push(0, 32'h510, 64'h5100, 16, 6, 0, 1, 0);
        push(0, 32'h520, 64'h5200, 16, 6, 0, 0, 0);
        expect_iss(32'h530);
        push(0, 32'h530, 64'h5300, 16, 7, 0, 0, 0);
        cycles(4);
        chk("R5 barrier holds group six", iss_total, base + 2);
        expect_iss(32'h510); expect_iss(32'h520);
        finish_cmd(32'h500);
        cycles(4);
        chk("R5 barrier released", iss_total, base + 4);
        finish_cmd(32'h510); finish_cmd(32'h520); finish_cmd(32'h530);

        // R6: sync holds everything behind it
        base = iss_total;
        expect_iss(32'h600);
        push(0, 32'h600, 64'h6000, 16, 8, 0, 0, 0);
        push(0, 32'h0, 64'h0, 0, 0, 0, 0, 1);
        push(0, 32'h610, 64'h6100, 16, 9, 0, 0, 0);
        cycles(5);
        chk("R6 sync holds other group", iss_total, base + 1);
        expect_iss(32'h610);
        finish_cmd(32'h600);
        cycles(4);
        chk("R6 sync retired", iss_total, base + 2);
        finish_cmd(32'h610);

        // R2: legality of sizes and alignment
        base = iss_total;
        push(0, 32'h700, 64'h7000, 3, 1, 0, 0, 0);
        chk("R2 size 3 rejected", cmd_err, 1);
        push(0, 32'h700, 64'h7000, 16400, 1, 0, 0, 0);
        chk("R2 size above 16K rejected", cmd_err, 1);
        push(0, 32'h708, 64'h7000, 16, 1, 0, 0, 0);
        chk("R2 misaligned local rejected", cmd_err, 1);
        push(0, 32'h700, 64'h7002, 4, 1, 0, 0, 0);
        chk("R2 misaligned external rejected", cmd_err, 1);
        push(0, 32'h700, 64'h7000, 0, 1, 0, 0, 0);
        chk("R2 size 0 rejected", cmd_err, 1);
        cycles(1);
        chk("R2 error pulse ends", cmd_err, 0);
        chk("R2 dropped commands not issued", iss_total, base);
        expect_iss(32'hA000);
        push(0, 32'hA000, 64'h10000, 16384, 2, 0, 0, 0);
        chk("R2 16K accepted", cmd_err, 0);
        expect_iss(32'hB001);
        push(0, 32'hB001, 64'h3, 1, 3, 0, 0, 0);
        chk("R2 single byte accepted", cmd_err, 0);
        cycles(3);
        chk("R2 legal commands issued", iss_total, base + 2);
        finish_cmd(32'hA000); finish_cmd(32'hB001);

        // R11: proxy port follows the same rules
        base = iss_total;
        chk("R11 proxy ready", px_ready, 1);
        expect_iss(32'hC008);
        push(1, 32'hC008, 64'h8, 8, 11, 0, 0, 0);
        chk("R11 proxy legal", cmd_err, 0);
        push(1, 32'hC000, 64'h0, 6, 11, 0, 0, 0);
        chk("R11 proxy illegal size", cmd_err, 1);
        expect_iss(32'hC100);
        push(1, 32'hC100, 64'h100, 16, 12, 0, 0, 0);
        push(1, 32'hC110, 64'h110, 16, 12, 1, 0, 0);
        cycles(4);
        chk("R11 proxy fence held", iss_total, base + 2);
        expect_iss(32'hC110);
        finish_cmd(32'hC100);
        cycles(3);
        chk("R11 proxy fence released", iss_total, base + 3);
        finish_cmd(32'hC008); finish_cmd(32'hC110);

        // R7 and R1: outstanding cap and full queue
        base = iss_total;
        for (int k = 0; k < 32; k++) begin
            expect_iss(32'h2000 + 32'(k * 16));
            push(0, 32'h2000 + 32'(k * 16), 64'(k * 16), 16, k % 32, 0, 0, 0);
        end
        cycles(3);
        chk("R7 sixteen in flight", iss_total, base + 16);
        chk("R1 queue full vacancy low", pu_vacancy, 0);
        push(0, 32'h3000, 64'h0, 16, 5, 0, 0, 0);
        chk("R1 write to full queue raises no error", cmd_err, 0);
        finish_cmd(32'h2000);
        cycles(3);
        chk("R7 completion frees a slot", iss_total, base + 17);
        chk("R1 vacancy back", pu_vacancy, 1);
        for (int k = 1; k < 32; k++) finish_cmd(32'h2000 + 32'(k * 16));
        cycles(3);
        chk("R1 write to full queue ignored", iss_total, base + 32);

        // R8: immediate query
        expect_iss(32'h800); expect_iss(32'h810);
        push(0, 32'h800, 64'h800, 16, 20, 0, 0, 0);
        push(0, 32'h810, 64'h810, 16, 22, 0, 0, 0);
        cycles(2);
        query(0, (32'd1 << 20) | (32'd1 << 21));
        wait_stat(5);
        chk("R8 immediate answered", stat_seen, 1);
        chk("R8 immediate bits", stat_last, 32'd1 << 21);
        cycles(2);
        chk("R8 status is a pulse", stat_valid, 0);

        // R9: any mode
        query(1, 32'd1 << 20);
        cycles(5);
        chk("R9 any waits while busy", stat_seen, 0);
        finish_cmd(32'h800);
        wait_stat(5);
        chk("R9 any answered", stat_seen, 1);
        chk("R9 any bits", stat_last, 32'd1 << 20);

        // R10: all mode
        expect_iss(32'h820);
        push(0, 32'h820, 64'h820, 16, 20, 0, 0, 0);
        cycles(2);
        query(2, (32'd1 << 20) | (32'd1 << 22));
        cycles(5);
        chk("R10 all waits while both busy", stat_seen, 0);
        finish_cmd(32'h810);
        cycles(5);
        chk("R10 all waits while one busy", stat_seen, 0);
        finish_cmd(32'h820);
        wait_stat(5);
        chk("R10 all answered", stat_seen, 1);
        chk("R10 all bits", stat_last, (32'd1 << 20) | (32'd1 << 22));

        chk("R3 no expected issue left", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            report();
        end
    end
endmodule